// File: doc/BRIEF.md
# Four-Channel Cycle-Steal DMA Engine

This block moves data between two addresses of a shared memory port without any work by the CPU. Four independent channels each hold a mode, a working source address, a working destination address and a remaining-transfer count. When a channel is enabled and its request line pulses, the engine takes the bus ahead of the CPU. It performs one read of 8, 16 or 32 bits at the source and writes the same data to the destination. It then gives the bus back. A CPU bus request is granted only while the engine is idle and has nothing pending.

The remaining count goes down by one after each completed write. When the final transfer finishes, the channel raises a one-cycle completion pulse. In single mode the channel then switches itself off. In repeat mode it refills its working source, destination and count from reload registers and stays enabled. When several channels are waiting, the lowest-numbered one is served first. A request that arrives while a move is under way is held until it can be served.

Top module: `cs_dma_engine`

## Requirements
- R1: While reset is active and directly after it, `mem_req` and `tc_done` are 0 and `cpu_gnt` follows `cpu_req`.
- R2: Each accepted request produces exactly one read at the working source address (`mem_we`=0), followed by one write at the working destination address (`mem_we`=1). The write carries the data returned by the read. `mem_size` equals the channel's size field: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits.
- R3: After a move, each address whose increment bit is set advances by 1, 2 or 4 (byte, halfword, word). An address whose bit is clear stays fixed.
- R4: `cpu_gnt` is 0 whenever a move is in progress or any channel has a latched request.
- R5: Latched requests are served lowest channel number first. If all four channels request in the same cycle, they are served in the order 0, 1, 2, 3.
- R6: A request that arrives during another channel's move is latched and served after that move.
- R7: The count drops by one per completed write. In single mode the transfer that starts with a count of 1 (or 0) is the last one. After it the channel is disabled and further requests cause no bus activity.
- R8: In repeat mode the last transfer reloads the working source, destination and count from the reload registers. The channel stays enabled, and the next move uses the reloaded addresses.
- R9: `tc_done[n]` is high for exactly one cycle after the final write of channel n, in both single and repeat modes.
- R10: A configuration write selects a register with `cfg_sel`: 0 mode, 1 source, 2 destination, 3 count, 4 source reload, 5 destination reload, 6 count reload. The mode word uses bit 0 for enable, bits 2:1 for size, bit 3 for source increment, bit 4 for destination increment and bit 5 for repeat. Requests to a channel whose enable bit is clear are ignored.
- R11: During a phase that has not been acknowledged, `mem_req`, `mem_we` and `mem_addr` hold their values until `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_chan | input | 2 | Channel addressed by the write |
| cfg_sel | input | 3 | Register select (see R10) |
| cfg_wdata | input | 32 | Configuration write data |
| dma_req | input | 4 | Per-channel transfer request pulses |
| cpu_req | input | 1 | CPU asks for the bus |
| cpu_gnt | output | 1 | CPU may use the bus this cycle |
| mem_req | output | 1 | Engine drives a bus phase |
| mem_we | output | 1 | 1 = write phase, 0 = read phase |
| mem_addr | output | 32 | Phase address |
| mem_size | output | 2 | Transfer size code |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data returned by memory |
| mem_ack | input | 1 | Memory accepts the current phase |
| tc_done | output | 4 | One-cycle completion pulse per channel |

## Verification
A corrupted working address shows up at `mem_addr` in the very next read or write phase of that channel, within about three cycles of its request. A wrong count or a missed reload shows up in one of two ways: the completion pulse appears on the wrong transfer, or a disabled channel still starts a move (or an enabled one does not). A fault in the pending latches or the arbiter changes the order of read addresses in a burst of simultaneous requests.

// File: rtl/cs_dma_pkg.sv
package cs_dma_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_READ  = 2'd1,
    SEQ_WRITE = 2'd2
  } seq_state_e;

  typedef enum logic [2:0] {
    RSEL_MODE   = 3'd0,
    RSEL_SRC    = 3'd1,
    RSEL_DST    = 3'd2,
    RSEL_CNT    = 3'd3,
    RSEL_SRC_RL = 3'd4,
    RSEL_DST_RL = 3'd5,
    RSEL_CNT_RL = 3'd6
  } reg_sel_e;

  // bit 0 enable, bits 2:1 size, bit 3 src inc, bit 4 dst inc, bit 5 repeat
  typedef struct packed {
    logic       rpt;
    logic       dst_inc;
    logic       src_inc;
    logic [1:0] size;
    logic       en;
  } chan_mode_t;

  localparam int MODE_W = $bits(chan_mode_t);

  function automatic logic [3:0] size_step(input logic [1:0] sz);
    case (sz)
      2'd0:    size_step = 4'd1;
      2'd1:    size_step = 4'd2;
      default: size_step = 4'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import cs_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              req_in,
  input  logic              take,
  input  logic              fin,
  output logic              pend,
  output chan_mode_t        mode,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              done
);

  chan_mode_t        mode_q, mode_n;
  logic [ADDR_W-1:0] src_q, src_n, dst_q, dst_n, src_rl_q, src_rl_n, dst_rl_q, dst_rl_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n, cnt_rl_q, cnt_rl_n;
  logic              pend_q, pend_n, done_q, done_n;
  logic              last;
  logic              data_ce;
  logic [ADDR_W-1:0] step;

  assign last    = (cnt_q <= CNT_W'(1));
  assign step    = ADDR_W'(size_step(mode_q.size));
  assign data_ce = wr_en | fin;

  always_comb begin
    mode_n   = mode_q;
    src_n    = src_q;
    dst_n    = dst_q;
    cnt_n    = cnt_q;
    src_rl_n = src_rl_q;
    dst_rl_n = dst_rl_q;
    cnt_rl_n = cnt_rl_q;
    done_n   = 1'b0;
    pend_n   = pend_q & ~take;
    if (req_in && mode_q.en) pend_n = 1'b1;

    if (fin) begin
      if (last) begin
        done_n = 1'b1;
        if (mode_q.rpt) begin
          src_n = src_rl_q;
          dst_n = dst_rl_q;
          cnt_n = cnt_rl_q;
        end else begin
          mode_n.en = 1'b0;
          cnt_n     = '0;
          pend_n    = 1'b0;
        end
      end else begin
        cnt_n = cnt_q - CNT_W'(1);
        if (mode_q.src_inc) src_n = src_q + step;
        if (mode_q.dst_inc) dst_n = dst_q + step;
      end
    end

    if (wr_en) begin
      case (reg_sel_e'(wr_sel))
        RSEL_MODE: begin
          mode_n = chan_mode_t'(wr_data[MODE_W-1:0]);
          if (!wr_data[0]) pend_n = 1'b0;
        end
        RSEL_SRC:    src_n    = wr_data;
        RSEL_DST:    dst_n    = wr_data;
        RSEL_CNT:    cnt_n    = wr_data[CNT_W-1:0];
        RSEL_SRC_RL: src_rl_n = wr_data;
        RSEL_DST_RL: dst_rl_n = wr_data;
        RSEL_CNT_RL: cnt_rl_n = wr_data[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      src_q    <= '0;
      dst_q    <= '0;
      cnt_q    <= '0;
      src_rl_q <= '0;
      dst_rl_q <= '0;
      cnt_rl_q <= '0;
    end else if (data_ce) begin
      mode_q   <= mode_n;
      src_q    <= src_n;
      dst_q    <= dst_n;
      cnt_q    <= cnt_n;
      src_rl_q <= src_rl_n;
      dst_rl_q <= dst_rl_n;
      cnt_rl_q <= cnt_rl_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      pend_q <= pend_n;
      done_q <= done_n;
    end
  end

  assign pend     = pend_q;
  assign mode     = mode_q;
  assign src_addr = src_q;
  assign dst_addr = dst_q;
  assign done     = done_q;

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  p_disabled_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q.en |-> !pend_q);

  p_repeat_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && last && mode_q.rpt && !wr_en) |=> (mode_q.en && cnt_q == $past(cnt_rl_q)
                                                && src_q == $past(src_rl_q)));

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int NCH   = 4,
  parameter int IDX_W = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   req,
  output logic [NCH-1:0]   gnt,
  output logic [IDX_W-1:0] idx,
  output logic             any
);

  logic found;

  always_comb begin
    gnt   = '0;
    idx   = '0;
    found = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (req[i] && !found) begin
        gnt[i] = 1'b1;
        idx    = IDX_W'(i);
        found  = 1'b1;
      end
    end
  end

  assign any = |req;

  p_gnt_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && ((gnt & ~req) == '0) && (any == (gnt != '0)));

  for (genvar g = 1; g < NCH; g++) begin : g_lowest
    localparam logic [NCH-1:0] BELOW = NCH'((1 << g) - 1);
    p_lowest_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[g] |-> ((req & BELOW) == '0));
  end

endmodule

// File: rtl/dma_bus_seq.sv
module dma_bus_seq
  import cs_dma_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_pend,
  input  logic [IDX_W-1:0]  pick_idx,
  input  logic [ADDR_W-1:0] cur_src,
  input  logic [ADDR_W-1:0] cur_dst,
  input  logic [1:0]        cur_size,
  input  logic              cpu_req,
  output logic              cpu_gnt,
  output logic              take,
  output logic              fin,
  output logic [IDX_W-1:0]  cur_idx,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);

  seq_state_e        state_q, state_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [DATA_W-1:0] data_q, data_n;
  logic              data_ce;

  always_comb begin
    state_n = state_q;
    idx_n   = idx_q;
    data_n  = data_q;
    take    = 1'b0;
    fin     = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (any_pend) begin
          take    = 1'b1;
          idx_n   = pick_idx;
          state_n = SEQ_READ;
        end
      end
      SEQ_READ: begin
        if (mem_ack) begin
          data_n  = mem_rdata;
          state_n = SEQ_WRITE;
        end
      end
      SEQ_WRITE: begin
        if (mem_ack) begin
          fin     = 1'b1;
          state_n = SEQ_IDLE;
        end
      end
      default: state_n = SEQ_IDLE;
    endcase
  end

  assign data_ce = (state_q == SEQ_READ) && mem_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_ce) data_q <= data_n;
  end

  assign cur_idx   = idx_q;
  assign mem_req   = (state_q != SEQ_IDLE);
  assign mem_we    = (state_q == SEQ_WRITE);
  assign mem_addr  = (state_q == SEQ_WRITE) ? cur_dst : cur_src;
  assign mem_size  = cur_size;
  assign mem_wdata = data_q;
  assign cpu_gnt   = cpu_req && (state_q == SEQ_IDLE) && !any_pend;

  p_cpu_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_gnt |-> !mem_req);

  p_pend_blocks_cpu_r4: assert property (@(posedge clk) disable iff (!rst_n)
    any_pend |-> !cpu_gnt);

  p_read_then_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we && mem_wdata == $past(mem_rdata)));

  p_phase_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

endmodule

// File: rtl/cs_dma_engine.sv
module cs_dma_engine
  import cs_dma_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  localparam int IDX_W = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_chan,
  input  logic [2:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic [NCH-1:0]    dma_req,
  input  logic              cpu_req,
  output logic              cpu_gnt,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic [NCH-1:0]    tc_done
);

  chan_mode_t        mode_a [NCH];
  logic [ADDR_W-1:0] src_a  [NCH];
  logic [ADDR_W-1:0] dst_a  [NCH];
  logic [NCH-1:0]    pend_v, gnt_v, done_v;
  logic [IDX_W-1:0]  pick_idx, cur_idx;
  logic              any_pend, take, fin;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    dma_chan_regs #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W)
    ) chan_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we && (cfg_chan == IDX_W'(g))),
      .wr_sel   (cfg_sel),
      .wr_data  (cfg_wdata),
      .req_in   (dma_req[g]),
      .take     (take && gnt_v[g]),
      .fin      (fin && (cur_idx == IDX_W'(g))),
      .pend     (pend_v[g]),
      .mode     (mode_a[g]),
      .src_addr (src_a[g]),
      .dst_addr (dst_a[g]),
      .done     (done_v[g])
    );
  end

  dma_prio_arb #(
    .NCH   (NCH),
    .IDX_W (IDX_W)
  ) arb_i (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (pend_v),
    .gnt   (gnt_v),
    .idx   (pick_idx),
    .any   (any_pend)
  );

  dma_bus_seq #(
    .NCH    (NCH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .any_pend  (any_pend),
    .pick_idx  (pick_idx),
    .cur_src   (src_a[cur_idx]),
    .cur_dst   (dst_a[cur_idx]),
    .cur_size  (mode_a[cur_idx].size),
    .cpu_req   (cpu_req),
    .cpu_gnt   (cpu_gnt),
    .take      (take),
    .fin       (fin),
    .cur_idx   (cur_idx),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_size  (mem_size),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ack   (mem_ack)
  );

  assign tc_done = done_v;

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tc_done) <= 1);

endmodule

// File: tb/cs_dma_engine_tb_top.sv
module cs_dma_engine_tb_top;

  localparam logic [31:0] RKEY = 32'hC0DE_0000;

  typedef struct packed {
    logic [1:0]  ch;
    logic [1:0]  sz;
    logic        si;
    logic        di;
    logic [31:0] src;
    logic [31:0] dst;
    logic [7:0]  cnt;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{ch:2'd0, sz:2'd0, si:1'b1, di:1'b1, src:32'h0100, dst:32'h0200, cnt:8'd3},
    '{ch:2'd1, sz:2'd1, si:1'b1, di:1'b0, src:32'h0310, dst:32'h0400, cnt:8'd2},
    '{ch:2'd2, sz:2'd2, si:1'b0, di:1'b1, src:32'h0500, dst:32'h0600, cnt:8'd3},
    '{ch:2'd3, sz:2'd2, si:1'b1, di:1'b1, src:32'h0700, dst:32'h0800, cnt:8'd2},
    '{ch:2'd0, sz:2'd1, si:1'b0, di:1'b0, src:32'h0900, dst:32'h0A00, cnt:8'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_chan;
  logic [2:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic [3:0]  dma_req;
  logic        cpu_req, cpu_gnt;
  logic        mem_req, mem_we, mem_ack, ack_en;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;
  logic [3:0]  tc_done;

  int checks = 0;
  int fails  = 0;

  logic        clr;
  int          log_n;
  logic        log_we   [64];
  logic [31:0] log_addr [64];
  logic [31:0] log_data [64];
  logic [1:0]  log_size [64];
  int          done_cnt [4];

  always #4 clk = ~clk;

  assign mem_ack   = mem_req & ack_en;
  assign mem_rdata = mem_addr ^ RKEY;

  cs_dma_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .dma_req(dma_req), .cpu_req(cpu_req), .cpu_gnt(cpu_gnt),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack), .tc_done(tc_done)
  );

  always @(posedge clk) begin
    if (clr) begin
      log_n <= 0;
      for (int i = 0; i < 4; i++) done_cnt[i] <= 0;
    end else begin
      if (rst_n && mem_req && mem_ack && log_n < 64) begin
        log_we[log_n]   <= mem_we;
        log_addr[log_n] <= mem_addr;
        log_data[log_n] <= mem_we ? mem_wdata : mem_rdata;
        log_size[log_n] <= mem_size;
        log_n           <= log_n + 1;
      end
      for (int i = 0; i < 4; i++) if (tc_done[i]) done_cnt[i] <= done_cnt[i] + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic [1:0] ch, input logic [2:0] sel, input logic [31:0] d);
    cfg_we = 1'b1; cfg_chan = ch; cfg_sel = sel; cfg_wdata = d;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] m);
    dma_req = m;
    tick(1);
    dma_req = '0;
  endtask

  task automatic clear_log();
    clr = 1'b1;
    tick(1);
    clr = 1'b0;
  endtask

  function automatic logic [31:0] mode_word(input bit rpt, input bit di, input bit si, input logic [1:0] sz);
    return {26'd0, rpt, di, si, sz, 1'b1};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_chan = '0; cfg_sel = '0; cfg_wdata = '0;
    dma_req = '0; cpu_req = 1'b1; ack_en = 1'b1; clr = 1'b1;
    tick(3);
    // R1: reset state
    chk(mem_req == 1'b0, "R1 mem_req in reset", 32'(mem_req), 0);
    chk(tc_done == 4'd0, "R1 tc_done in reset", 32'(tc_done), 0);
    chk(cpu_gnt == 1'b1, "R1 cpu_gnt follows cpu_req", 32'(cpu_gnt), 1);
    rst_n = 1'b1;
    tick(1);
    clr = 1'b0;
    cpu_req = 1'b0;

    // R10: disabled channel ignores requests
    pulse(4'b0100);
    tick(6);
    chk(log_n == 0, "R10 disabled channel moved data", 32'(log_n), 0);

    // Vector walk: R2, R3, R7, R9
    foreach (VECS[v]) begin
      automatic vec_t t = VECS[v];
      automatic logic [31:0] stp = 32'd1 << t.sz;
      clear_log();
      cfg(t.ch, 3'd1, t.src);
      cfg(t.ch, 3'd2, t.dst);
      cfg(t.ch, 3'd3, 32'(t.cnt));
      cfg(t.ch, 3'd0, mode_word(1'b0, t.di, t.si, t.sz));
      for (int k = 0; k < int'(t.cnt); k++) begin
        pulse(4'b0001 << t.ch);
        tick(5);
      end
      chk(log_n == 2 * int'(t.cnt), "R7 moves per count", 32'(log_n), 32'(2 * t.cnt));
      for (int k = 0; k < int'(t.cnt); k++) begin
        automatic logic [31:0] es = t.src + (t.si ? stp * 32'(k) : 32'd0);
        automatic logic [31:0] ed = t.dst + (t.di ? stp * 32'(k) : 32'd0);
        chk(!log_we[2*k] && log_addr[2*k] == es, "R3 read address", log_addr[2*k], es);
        chk(log_size[2*k] == t.sz, "R2 transfer size", 32'(log_size[2*k]), 32'(t.sz));
        chk(log_we[2*k+1] && log_addr[2*k+1] == ed, "R3 write address", log_addr[2*k+1], ed);
        chk(log_data[2*k+1] == (es ^ RKEY), "R2 write data", log_data[2*k+1], es ^ RKEY);
      end
      chk(done_cnt[t.ch] == 1, "R9 completion pulse count", 32'(done_cnt[t.ch]), 1);
      pulse(4'b0001 << t.ch);
      tick(6);
      chk(log_n == 2 * int'(t.cnt), "R7 request after terminal count", 32'(log_n), 32'(2 * t.cnt));
    end

    // R5: simultaneous requests on all channels
    clear_log();
    for (int c = 0; c < 4; c++) begin
      cfg(2'(c), 3'd1, 32'h1000 + 32'(c) * 32'h100);
      cfg(2'(c), 3'd2, 32'h5000 + 32'(c) * 32'h100);
      cfg(2'(c), 3'd3, 32'd1);
      cfg(2'(c), 3'd0, mode_word(1'b0, 1'b1, 1'b1, 2'd2));
    end
    pulse(4'b1111);
    tick(20);
    chk(log_n == 8, "R5 burst move count", 32'(log_n), 8);
    for (int k = 0; k < 4; k++)
      chk(log_addr[2*k] == 32'h1000 + 32'(k) * 32'h100, "R5 service order",
          log_addr[2*k], 32'h1000 + 32'(k) * 32'h100);

    // R6, R11, R4: request during a stalled move
    clear_log();
    cfg(2'd3, 3'd1, 32'h1300); cfg(2'd3, 3'd3, 32'd1); cfg(2'd3, 3'd0, mode_word(1'b0, 1'b1, 1'b1, 2'd2));
    cfg(2'd0, 3'd1, 32'h1000); cfg(2'd0, 3'd3, 32'd1); cfg(2'd0, 3'd0, mode_word(1'b0, 1'b1, 1'b1, 2'd2));
    ack_en = 1'b0;
    cpu_req = 1'b1;
    pulse(4'b1000);
    tick(2);
    chk(mem_req && !mem_we && mem_addr == 32'h1300, "R11 read phase held", mem_addr, 32'h1300);
    chk(cpu_gnt == 1'b0, "R4 cpu stalled during move", 32'(cpu_gnt), 0);
    pulse(4'b0001);
    tick(2);
    chk(mem_req && !mem_we && mem_addr == 32'h1300, "R11 phase still held", mem_addr, 32'h1300);
    ack_en = 1'b1;
    tick(12);
    chk(log_n == 4, "R6 latched request served", 32'(log_n), 4);
    chk(log_addr[0] == 32'h1300, "R6 first served", log_addr[0], 32'h1300);
    chk(log_addr[2] == 32'h1000, "R6 latched second", log_addr[2], 32'h1000);
    chk(cpu_gnt == 1'b1, "R4 cpu granted when idle", 32'(cpu_gnt), 1);
    cpu_req = 1'b0;

    // R8, R9: repeat mode reload
    clear_log();
    cfg(2'd1, 3'd1, 32'h2000); cfg(2'd1, 3'd2, 32'h3000); cfg(2'd1, 3'd3, 32'd2);
    cfg(2'd1, 3'd4, 32'h2100); cfg(2'd1, 3'd5, 32'h3100); cfg(2'd1, 3'd6, 32'd2);
    cfg(2'd1, 3'd0, mode_word(1'b1, 1'b1, 1'b1, 2'd2));
    for (int k = 0; k < 4; k++) begin
      pulse(4'b0010);
      tick(5);
    end
    chk(log_n == 8, "R8 channel stays enabled", 32'(log_n), 8);
    chk(log_addr[2] == 32'h2004, "R3 word increment", log_addr[2], 32'h2004);
    chk(log_addr[4] == 32'h2100, "R8 reloaded source", log_addr[4], 32'h2100);
    chk(log_addr[5] == 32'h3100, "R8 reloaded destination", log_addr[5], 32'h3100);
    chk(log_addr[6] == 32'h2104, "R8 reloaded source advances", log_addr[6], 32'h2104);
    chk(done_cnt[1] == 2, "R9 repeat completion pulses", 32'(done_cnt[1]), 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule